// File: doc/BRIEF.md
# Cross-Domain Timer Register Update Bridge

This block connects a fast system-clock register bus to a small timer that runs on a slow, unrelated clock, such as a watch-crystal domain. Software writes three timer registers through the bus: a control word, a compare value and a count value. Each write first lands in a holding register on the system side. A toggle handshake then carries it across to the slow domain, where it is committed. Each register has its own busy flag. The flag stays set from the write until the slow-domain commit has been seen back on the system side.

Bus reads differ by register. The control and compare addresses return their holding registers. The count address returns the live count from the timer, brought across with a Gray-coded two-flop synchronizer. A status address returns the three busy flags. A write aimed at a register whose transfer is still in flight is dropped and reported on a one-cycle flag. The timer stub counts up on each slow-clock edge while its enable bit is set. The system clock must run more than four times faster than the slow clock.

Top module: `tmr_xdom_bridge`

## Requirements
- R1: After reset, the status read is zero, both holding registers read zero, and the committed count, compare and control values are zero.
- R2: A write to address 0 (control), 1 (compare) or 2 (count) whose busy flag is clear sets that flag on the following system clock cycle. The flag index equals the address.
- R3: While a register's busy flag is set, its holding register keeps the value last accepted. A readback of the control or compare address during the transfer returns the written value.
- R4: The held value is committed to the slow-domain register within three slow-clock rising edges of the write. The busy flag clears only after that commit, and no later than three system cycles after it.
- R5: Transfers to the three registers are independent. Writes to all three in consecutive cycles leave all three busy flags set at once, and each register commits its own value.
- R6: Reads are combinational on the address. Address 0 returns the control holding register and address 1 the compare holding register. Address 3 returns status with count-busy at bit 2, compare-busy at bit 1, control-busy at bit 0, and zeros above.
- R7: A write to a register whose busy flag is set is not accepted. The wr_clash_o output is high for exactly the cycle after that write.
- R8: While bit 0 of the committed control word is 1, the committed count increments by one on each slow-clock edge. A committed count write replaces the increment on its commit edge. With bit 0 at 0, the count holds.
- R9: A read of address 2 returns the live count, synchronized into the system domain. It advances while the timer is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System (bus) clock |
| aclk_i | input | 1 | Slow asynchronous timer clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | 2 | Register select: 0 control, 1 compare, 2 count, 3 status |
| wdata_i | input | DW | Bus write data |
| rdata_o | output | DW | Bus read data for addr_i |
| busy_o | output | 3 | Per-register transfer-in-flight flags |
| wr_clash_o | output | 1 | Pulse: write dropped because its register was busy |
| cnt_o | output | DW | Committed live count (slow domain) |
| cmp_o | output | DW | Committed compare value (slow domain) |
| ctrl_o | output | DW | Committed control word, bit 0 enables counting |

## Verification
A lost or doubled request toggle shows up at the ports in one of two ways. The busy flag may stay set until the poll times out, or it may clear with the committed output still holding its old value. Either is visible a few slow-clock periods after the write. A holding register that changes during its transfer shows at once in the control or compare readback, and later as a wrong committed value. A broken Gray conversion or increment path shows in the count readback within two system cycles of the slow-clock edge that caused it. A mix-up between flag indices shows in the status read on the cycle after the write.

// File: rtl/tmr_xdom_pkg.sv
package tmr_xdom_pkg;
  localparam int NUM_REGS = 3;
  localparam int IDX_CTRL = 0;
  localparam int IDX_CMP  = 1;
  localparam int IDX_CNT  = 2;
  localparam int EN_BIT   = 0;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CMP  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_sync2.sv
module tmr_sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/tmr_xfer_chan.sv
module tmr_xfer_chan #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          aclk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] hold_o,
  output logic          busy_o,
  output logic          commit_o
);
  logic [DW-1:0] hold_q;
  logic          req_q, req_s, ack_q, ack_s;

  // system side: holding register and request toggle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      req_q  <= 1'b0;
    end else if (wr_i) begin
      hold_q <= wdata_i;
      req_q  <= ~req_q;
    end
  end

  tmr_sync2 #(.W(1)) u_req_sync (
    .clk_i (aclk_i),
    .rst_ni(rst_ni),
    .d_i   (req_q),
    .q_o   (req_s)
  );

  // slow side: a toggle difference is a commit; acknowledge by following it
  always_ff @(posedge aclk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= req_s;
  end

  assign commit_o = req_s ^ ack_q;

  tmr_sync2 #(.W(1)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_q),
    .q_o   (ack_s)
  );

  assign busy_o = req_q ^ ack_s;
  assign hold_o = hold_q;
endmodule

// File: rtl/tmr_cnt_stub.sv
module tmr_cnt_stub
  import tmr_xdom_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                         aclk_i,
  input  logic                         rst_ni,
  input  logic [NUM_REGS-1:0]          commit_i,
  input  logic [NUM_REGS-1:0][DW-1:0]  hold_i,
  output logic [DW-1:0]                cnt_o,
  output logic [DW-1:0]                cmp_o,
  output logic [DW-1:0]                ctrl_o,
  output logic [DW-1:0]                gray_o
);
  logic [DW-1:0] cnt_q, cnt_d, cmp_q, ctrl_q, gray_q;

  always_comb begin
    if (commit_i[IDX_CNT])     cnt_d = hold_i[IDX_CNT];
    else if (ctrl_q[EN_BIT])   cnt_d = cnt_q + 1'b1;
    else                       cnt_d = cnt_q;
  end

  always_ff @(posedge aclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      ctrl_q <= '0;
      gray_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      gray_q <= cnt_d ^ (cnt_d >> 1);
      if (commit_i[IDX_CMP])  cmp_q  <= hold_i[IDX_CMP];
      if (commit_i[IDX_CTRL]) ctrl_q <= hold_i[IDX_CTRL];
    end
  end

  assign cnt_o  = cnt_q;
  assign cmp_o  = cmp_q;
  assign ctrl_o = ctrl_q;
  assign gray_o = gray_q;
endmodule

// File: rtl/tmr_xdom_bridge.sv
module tmr_xdom_bridge
  import tmr_xdom_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                clk_i,
  input  logic                aclk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [1:0]          addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic [NUM_REGS-1:0] busy_o,
  output logic                wr_clash_o,
  output logic [DW-1:0]       cnt_o,
  output logic [DW-1:0]       cmp_o,
  output logic [DW-1:0]       ctrl_o
);
  localparam int NR = NUM_REGS;

  logic [NR-1:0]         sel_w, wr_w, busy_w, commit_w, clash_v;
  logic [NR-1:0][DW-1:0] hold_w;
  logic [DW-1:0]         gray_a, gray_s, cnt_rd;
  logic                  clash_q;

  for (genvar i = 0; i < NR; i++) begin : g_chan
    assign sel_w[i]   = wr_en_i && (addr_i == 2'(i));
    assign wr_w[i]    = sel_w[i] && !busy_w[i];
    assign clash_v[i] = sel_w[i] && busy_w[i];

    tmr_xfer_chan #(.DW(DW)) u_chan (
      .clk_i   (clk_i),
      .aclk_i  (aclk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_w[i]),
      .wdata_i (wdata_i),
      .hold_o  (hold_w[i]),
      .busy_o  (busy_w[i]),
      .commit_o(commit_w[i])
    );
  end

  tmr_cnt_stub #(.DW(DW)) u_stub (
    .aclk_i  (aclk_i),
    .rst_ni  (rst_ni),
    .commit_i(commit_w),
    .hold_i  (hold_w),
    .cnt_o   (cnt_o),
    .cmp_o   (cmp_o),
    .ctrl_o  (ctrl_o),
    .gray_o  (gray_a)
  );

  tmr_sync2 #(.W(DW)) u_gray_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gray_a),
    .q_o   (gray_s)
  );

  always_comb begin
    cnt_rd[DW-1] = gray_s[DW-1];
    for (int b = DW - 2; b >= 0; b--) cnt_rd[b] = cnt_rd[b+1] ^ gray_s[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clash_q <= 1'b0;
    else         clash_q <= |clash_v;
  end

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      SEL_CTRL: rdata_o = hold_w[IDX_CTRL];
      SEL_CMP:  rdata_o = hold_w[IDX_CMP];
      SEL_CNT:  rdata_o = cnt_rd;
      default:  rdata_o = DW'(busy_w);
    endcase
  end

  assign busy_o     = busy_w;
  assign wr_clash_o = clash_q;
endmodule

// File: rtl/tmr_xdom_bridge_chk.sv
module tmr_xdom_bridge_chk
  import tmr_xdom_pkg::*;
#(
  parameter int DW = 8
) (
  input logic                        clk_i,
  input logic                        aclk_i,
  input logic                        rst_ni,
  input logic                        wr_en_i,
  input logic [1:0]                  addr_i,
  input logic [NUM_REGS-1:0]         busy_i,
  input logic                        clash_i,
  input logic [NUM_REGS-1:0]         commit_i,
  input logic [NUM_REGS-1:0][DW-1:0] hold_i,
  input logic [DW-1:0]               cnt_i,
  input logic [DW-1:0]               cmp_i,
  input logic [DW-1:0]               ctrl_i
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    a_r2_busy_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == 2'(i) && !busy_i[i]) |=> busy_i[i]);
    a_r7_clash_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == 2'(i) && busy_i[i]) |=> clash_i);
    a_r3_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_i[i] |=> $stable(hold_i[i]));
  end

  a_r4_cmp_load: assert property (@(posedge aclk_i) disable iff (!rst_ni)
    commit_i[IDX_CMP] |=> cmp_i == $past(hold_i[IDX_CMP]));
  a_r8_cnt_load: assert property (@(posedge aclk_i) disable iff (!rst_ni)
    commit_i[IDX_CNT] |=> cnt_i == $past(hold_i[IDX_CNT]));
  a_r8_cnt_step: assert property (@(posedge aclk_i) disable iff (!rst_ni)
    (ctrl_i[EN_BIT] && !commit_i[IDX_CNT]) |=> cnt_i == DW'($past(cnt_i) + 1'b1));
  a_r8_cnt_hold: assert property (@(posedge aclk_i) disable iff (!rst_ni)
    (!ctrl_i[EN_BIT] && !commit_i[IDX_CNT]) |=> $stable(cnt_i));
endmodule

bind tmr_xdom_bridge tmr_xdom_bridge_chk #(.DW(DW)) u_chk (
  .clk_i   (clk_i),
  .aclk_i  (aclk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .busy_i  (busy_w),
  .clash_i (wr_clash_o),
  .commit_i(commit_w),
  .hold_i  (hold_w),
  .cnt_i   (cnt_o),
  .cmp_i   (cmp_o),
  .ctrl_i  (ctrl_o)
);

// File: tb/tmr_xdom_bridge_tb.sv
`timescale 1ns/1ps
module tmr_xdom_bridge_tb;
  localparam int DW = 8;

  logic          clk = 0, aclk = 0, rst_n = 0;
  logic          wr_en = 0;
  logic [1:0]    addr = 2'd3;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, cnt, cmp, ctrl;
  logic [2:0]    busy;
  logic          clash;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  tmr_xdom_bridge #(.DW(DW)) u_dut (
    .clk_i(clk), .aclk_i(aclk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .busy_o(busy), .wr_clash_o(clash),
    .cnt_o(cnt), .cmp_o(cmp), .ctrl_o(ctrl)
  );

  always #10 clk = ~clk;                       // 50 MHz
  initial begin #7; forever #115 aclk = ~aclk; end  // 230 ns, ratio > 4

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // ctrl writes in the random phase keep the enable bit clear
  function automatic logic [DW-1:0] exp_commit(input int r, input logic [DW-1:0] d);
    return (r == 0) ? (d & ~DW'(1)) : d;
  endfunction

  function automatic logic [DW-1:0] committed(input int r);
    return (r == 0) ? ctrl : (r == 1) ? cmp : cnt;
  endfunction

  task automatic wr(input int a, input logic [DW-1:0] d);
    wr_en = 1; addr = 2'(a); wdata = d;
    @(negedge clk);
    wr_en = 0; addr = 2'd3;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] v);
    addr = 2'(a);
    #1 v = rdata;
  endtask

  task automatic wait_idle(input int r);
    int n = 0;
    while (busy[r] && n < 300) begin @(negedge clk); n++; end
    if (n >= 300) chk(0, "R4 busy timeout", busy, 0);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "R4 watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [DW-1:0] v, c1, c2, d;
    int r;
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(3, v); chk(v == 0, "R1 status", v, 0);
    rd(0, v); chk(v == 0, "R1 ctrl hold", v, 0);
    rd(1, v); chk(v == 0, "R1 cmp hold", v, 0);
    chk(cnt == 0 && cmp == 0 && ctrl == 0, "R1 committed", cnt | cmp | ctrl, 0);

    // random transfers
    for (int it = 0; it < 24; it++) begin
      r = $urandom_range(0, 2);
      d = exp_commit(r, DW'($urandom));
      wr(r, d);
      rd(3, v); chk(v == DW'(1 << r), "R2 busy bit", v, 1 << r);
      if (r < 2) begin rd(r, v); chk(v == d, "R3 hold readback", v, d); end
      wait_idle(r);
      chk(committed(r) == d, "R4 commit", committed(r), d);
      if (r == 2) begin
        @(negedge clk);
        rd(2, v); chk(v == d, "R9 count readback", v, d);
      end
    end

    // R5 three transfers at once
    wr(0, 8'h40); wr(1, 8'hA5); wr(2, 8'h3C);
    rd(3, v); chk(v == 8'h07, "R5 all busy", v, 8'h07);
    wait_idle(0); wait_idle(1); wait_idle(2);
    chk(ctrl == 8'h40, "R5 ctrl", ctrl, 8'h40);
    chk(cmp == 8'hA5, "R5 cmp", cmp, 8'hA5);
    chk(cnt == 8'h3C, "R5 cnt", cnt, 8'h3C);
    rd(3, v); chk(v == 0, "R6 status idle", v, 0);

    // R7 write while busy
    wr(1, 8'h11);
    chk(clash == 0, "R7 no clash first", clash, 0);
    wr(1, 8'h22);
    chk(clash == 1, "R7 clash pulse", clash, 1);
    @(negedge clk);
    chk(clash == 0, "R7 clash one cycle", clash, 0);
    wait_idle(1);

    // R8 / R9 counting
    wr(2, 8'h10); wait_idle(2);
    wr(0, 8'h01); wait_idle(0);
    rd(2, c1);
    repeat (115) @(negedge clk);
    rd(2, c2);
    v = c2 - c1;
    chk(v >= 9 && v <= 11, "R9 count advances", v, 10);
    wr(2, 8'hF0); wait_idle(2);
    v = cnt - 8'hF0;
    chk(v <= 1, "R8 load overrides increment", cnt, 8'hF0);
    wr(0, 8'h00); wait_idle(0);
    c1 = cnt;
    repeat (50) @(negedge clk);
    chk(cnt == c1, "R8 count holds when disabled", cnt, c1);

    finish_run();
  end
endmodule